// File: doc/BRIEF.md
# UART FIFO Control and DMA Request Logic

This block holds the queueing side of a 16550-style serial port: a transmit queue and a receive queue of parameterised depth, a write-only 8-bit control register, receive threshold detection, an auto flow-control output and two active-low DMA request lines. The serialiser, baud generator and line status logic sit outside. They move characters with one push or pop strobe per queue and see the occupancy, full and empty flags.

A single control write does four things. It sets the receive threshold and the DMA signalling style. It switches between queued operation and single-entry holding-register operation. It can also flush either queue or both through bits that do not stay set. After any write that flushes a queue, a busy flag stays high for a fixed number of cycles so that data accesses can be held off.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset both queues are empty, busy is low, queueing is off, the threshold code is 00, DMA style is 0, dma_tx_req_n is low and dma_rx_req_n is high.
- R2: Control bit 0 set gives each queue a capacity of DEPTH entries. Bit 0 clear gives a capacity of 1. A push into a full queue is ignored and leaves the level unchanged.
- R3: Each queue returns characters in the order they were pushed, with the head visible on the read data port. A pop of an empty queue is ignored.
- R4: Control bits [7:6] select the receive threshold while queueing is on: 00 gives 1, 01 gives DEPTH/4, 10 gives DEPTH/2, 11 gives DEPTH-2. While queueing is off the threshold is 1. rx_avail is high exactly when the receive level is at or above the threshold.
- R5: With afc_en high, rts_n is high exactly when the receive level is at or above the threshold. With afc_en low, rts_n is low.
- R6: With control bit 3 clear, dma_tx_req_n is low exactly when the transmit queue is empty.
- R7: With control bit 3 set, dma_tx_req_n goes low when the transmit queue is empty and stays low while the queue fills. It goes high when the queue is full and stays high until the queue is empty again.
- R8: With control bit 3 clear, dma_rx_req_n is low exactly when the receive queue holds at least one character.
- R9: With control bit 3 set, dma_rx_req_n goes low once the receive level reaches the threshold or rx_timeout is high while the queue is not empty. It then stays low until the queue is empty.
- R10: Control bit 2 empties the transmit queue and bit 1 empties the receive queue, each on the write's clock edge. Neither bit is retained, so a later write with the bit clear leaves the queue contents alone.
- R11: A write that changes bit 0 empties both queues. A write that keeps bit 0 at its value does not.
- R12: busy goes high on the edge of a write that flushes any queue and stays high for exactly BUSY_CYC (default 8) cycles.
- R13: A flush has priority over a push on the same edge, so the queue is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| afc_en | input | 1 | Auto flow control enable |
| rx_timeout | input | 1 | Character timeout indication from the receiver |
| tx_push | input | 1 | Push strobe for the transmit queue |
| tx_wdata | input | DW | Character to push into the transmit queue |
| tx_pop | input | 1 | Pop strobe for the transmit queue |
| tx_rdata | output | DW | Head of the transmit queue |
| tx_level | output | LW | Transmit occupancy |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_empty | output | 1 | Transmit queue empty |
| rx_push | input | 1 | Push strobe for the receive queue |
| rx_wdata | input | DW | Character to push into the receive queue |
| rx_pop | input | 1 | Pop strobe for the receive queue |
| rx_rdata | output | DW | Head of the receive queue |
| rx_level | output | LW | Receive occupancy |
| rx_full | output | 1 | Receive queue at capacity |
| rx_empty | output | 1 | Receive queue empty |
| rx_avail | output | 1 | Received-data-available interrupt condition |
| rts_n | output | 1 | Flow-control request-to-send, active low |
| dma_tx_req_n | output | 1 | Transmit DMA request, active low |
| dma_rx_req_n | output | 1 | Receive DMA request, active low |
| busy | output | 1 | Hold-off window after a flush |

## Verification
The hardest state to reach from the ports is the latched part of the burst-style receive request. That state is a queue that has already dropped below its threshold but still asserts the request because it crossed the threshold, or saw a timeout, earlier. The stimulus fills the receive queue past the threshold, drains it one character at a time, and checks that the request holds until the last pop. It then sets up the same latch with a one-cycle rx_timeout pulse on a single stored character. The threshold and occupancy conditions are swept over every code and every level from 0 to DEPTH, and each expected value is computed from the code table.

// File: rtl/uart_fifo_ctl_pkg.sv
// Shared types and helpers for the UART queue control block.
package uart_fifo_ctl_pkg;

    // Receive threshold codes, as written to control bits [7:6].
    typedef enum logic [1:0] {
        TRIG_ONE       = 2'b00,
        TRIG_QUARTER   = 2'b01,
        TRIG_HALF      = 2'b10,
        TRIG_NEAR_FULL = 2'b11
    } trig_sel_e;

    // Retained part of the control register.
    typedef struct packed {
        trig_sel_e trig;
        logic      burst_dma;
        logic      fifo_on;
    } ctl_cfg_t;

    // Occupancy at which the receive threshold is reached.
    function automatic int unsigned trig_count(trig_sel_e t, logic fifo_on, int unsigned depth);
        if (!fifo_on) return 1;
        case (t)
            TRIG_QUARTER:   return depth / 4;
            TRIG_HALF:      return depth / 2;
            TRIG_NEAR_FULL: return depth - 2;
            default:        return 1;
        endcase
    endfunction

endpackage

// File: rtl/ufc_cfg_reg.sv
// Control register: keeps the threshold, DMA style and queue enable, and
// turns flush bits and enable changes into one-cycle clear pulses. It also
// runs the post-flush busy window.
// Assumes: writes are single-cycle strobes; bits [5:4] carry nothing.
module ufc_cfg_reg
    import uart_fifo_ctl_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  logic [7:0] cfg_wdata,
    output ctl_cfg_t cfg,
    output logic     tx_clr,
    output logic     rx_clr,
    output logic     busy
);
    localparam int unsigned BW = $clog2(BUSY_CYC + 1);

    logic          en_flip;
    logic [BW-1:0] busy_cnt;
    logic [1:0]    unused_bits;

    assign unused_bits = cfg_wdata[5:4];

    // Clear pulses: explicit flush bit, or a change of the enable bit.
    always_comb begin
        en_flip = cfg_we && (cfg_wdata[0] != cfg.fifo_on);
        tx_clr  = (cfg_we && cfg_wdata[2]) || en_flip;
        rx_clr  = (cfg_we && cfg_wdata[1]) || en_flip;
    end

    // Retained control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{trig: TRIG_ONE, burst_dma: 1'b0, fifo_on: 1'b0};
        end else if (cfg_we) begin
            cfg.trig      <= trig_sel_e'(cfg_wdata[7:6]);
            cfg.burst_dma <= cfg_wdata[3];
            cfg.fifo_on   <= cfg_wdata[0];
        end
    end

    // Busy window: reload on any flush, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (tx_clr || rx_clr) begin
            busy_cnt <= BW'(BUSY_CYC);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign busy = (busy_cnt != '0);

endmodule

// File: rtl/ufc_fifo.sv
// Circular character queue with a run-time capacity limit (DEPTH or 1),
// head shown on rdata, and a synchronous clear that wins over push and pop.
// Assumes: DEPTH >= 4; pushes to a full queue and pops of an empty one
// are dropped.
module ufc_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    // Accept conditions against the current capacity.
    always_comb begin
        full    = (level >= cap);
        empty   = (level == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
    end

    // Pointer step with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/ufc_dma_req.sv
// DMA request generation for both directions in single-transfer and burst
// styles. Burst style keeps a latch per direction between the start and
// stop conditions.
// Assumes: flags come straight from the queues in the same cycle.
module ufc_dma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic tx_empty,
    input  logic tx_full,
    input  logic rx_empty,
    input  logic rx_clr,
    input  logic rx_at_trig,
    input  logic rx_timeout,
    output logic tx_req_n,
    output logic rx_req_n
);
    logic tx_hold, rx_hold;
    logic rx_start;

    assign rx_start = rx_at_trig || rx_timeout;

    // Transmit burst latch: set on empty, cleared on full.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_hold <= 1'b1;
        else if (tx_empty) tx_hold <= 1'b1;
        else if (tx_full)  tx_hold <= 1'b0;
    end

    // Receive burst latch: set at threshold or timeout, cleared on empty.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr || rx_empty) rx_hold <= 1'b0;
        else if (rx_start)                rx_hold <= 1'b1;
    end

    // Request outputs for the selected style.
    always_comb begin
        if (burst_mode) begin
            tx_req_n = !((tx_empty || tx_hold) && !tx_full);
            rx_req_n = !(!rx_empty && (rx_hold || rx_start));
        end else begin
            tx_req_n = !tx_empty;
            rx_req_n = rx_empty;
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
// Top of the UART queue control block: control register, two queues,
// receive threshold detection, flow control and DMA requests.
// Assumes: DEPTH is a power of two, at least 4; synchronous active-low reset.
module uart_fifo_ctl
    import uart_fifo_ctl_pkg::*;
#(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned BUSY_CYC = 8,
    localparam int unsigned LW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          afc_en,
    input  logic          rx_timeout,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    output logic [LW-1:0] tx_level,
    output logic          tx_full,
    output logic          tx_empty,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic [LW-1:0] rx_level,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_avail,
    output logic          rts_n,
    output logic          dma_tx_req_n,
    output logic          dma_rx_req_n,
    output logic          busy
);
    ctl_cfg_t      cfg;
    logic          tx_clr, rx_clr;
    logic [LW-1:0] cap, thr;
    logic          at_trig;

    ufc_cfg_reg #(.BUSY_CYC(BUSY_CYC)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg(cfg), .tx_clr(tx_clr), .rx_clr(rx_clr), .busy(busy)
    );

    // Capacity and threshold from the retained settings.
    always_comb begin
        cap     = cfg.fifo_on ? LW'(DEPTH) : LW'(1);
        thr     = LW'(trig_count(cfg.trig, cfg.fifo_on, DEPTH));
        at_trig = (rx_level >= thr);
    end

    ufc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    ufc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    ufc_dma_req u_dma (
        .clk(clk), .rst_n(rst_n), .burst_mode(cfg.burst_dma),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
        .rx_clr(rx_clr), .rx_at_trig(at_trig), .rx_timeout(rx_timeout),
        .tx_req_n(dma_tx_req_n), .rx_req_n(dma_rx_req_n)
    );

    // Interrupt condition and flow control follow the threshold.
    assign rx_avail = at_trig;
    assign rts_n    = afc_en && at_trig;

endmodule

// File: rtl/ufc_checker.sv
// Property checker for uart_fifo_ctl, attached by bind.
module ufc_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic          afc_en,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_full,
    input logic          rx_empty,
    input logic          rx_avail,
    input logic          rts_n,
    input logic          dma_tx_req_n,
    input logic          dma_rx_req_n,
    input logic          busy
);
    p_tx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[2] |=> tx_level == '0);

    p_rx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[1] |=> rx_level == '0);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tx_level) <= 32'($past(tx_level)) + 1);

    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_wdata[2] || cfg_wdata[1]) |=> busy);

    p_txreq_not_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_tx_req_n |-> !tx_full);

    p_rxreq_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> dma_rx_req_n);

    p_rts_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !afc_en |-> !rts_n);

    p_rts_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        afc_en |-> (rts_n == rx_avail));

endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_fifo_ctl.sv
// Self-checking bench for uart_fifo_ctl with default parameters.
module tb_uart_fifo_ctl;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic afc_en = 1'b0, rx_timeout = 1'b0;
    logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic [LW-1:0] tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty, rx_avail, rts_n;
    logic dma_tx_req_n, dma_rx_req_n, busy;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uart_fifo_ctl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .afc_en(afc_en), .rx_timeout(rx_timeout),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_full(rx_full), .rx_empty(rx_empty),
        .rx_avail(rx_avail), .rts_n(rts_n), .dma_tx_req_n(dma_tx_req_n),
        .dma_rx_req_n(dma_rx_req_n), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick; @(posedge clk); #1; endtask
    task automatic wr_cfg(input logic [7:0] v);
        cfg_wdata = v; cfg_we = 1'b1; tick(); cfg_we = 1'b0; #1;
    endtask
    task automatic push_tx(input logic [7:0] d);
        tx_wdata = d; tx_push = 1'b1; tick(); tx_push = 1'b0; #1;
    endtask
    task automatic pop_tx; tx_pop = 1'b1; tick(); tx_pop = 1'b0; #1; endtask
    task automatic push_rx(input logic [7:0] d);
        rx_wdata = d; rx_push = 1'b1; tick(); rx_push = 1'b0; #1;
    endtask
    task automatic pop_rx; rx_pop = 1'b1; tick(); rx_pop = 1'b0; #1; endtask

    function automatic int thr_of(input int code);
        case (code)
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            3: return DEPTH - 2;
            default: return 1;
        endcase
    endfunction

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1; #1;
        // R1 reset state
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 busy", busy, 0);
        chk("R1 tx_req_n", dma_tx_req_n, 0);
        chk("R1 rx_req_n", dma_rx_req_n, 1);
        chk("R1 rx_avail", rx_avail, 0);

        // R2 holding mode: capacity 1, second push dropped
        push_tx(8'hA1);
        push_tx(8'hA2);
        chk("R2 hold level", tx_level, 1);
        chk("R2 hold full", tx_full, 1);
        chk("R3 hold data", tx_rdata, 8'hA1);

        // R11 enable change flushes; R12 busy window length
        wr_cfg(8'h01);
        chk("R11 flush on enable", tx_level, 0);
        chk("R12 busy start", busy, 1);
        for (int i = 1; i < 8; i++) begin
            tick();
            chk("R12 busy held", busy, 1);
        end
        tick();
        chk("R12 busy end", busy, 0);

        // R2/R6 fill in queued mode, single-transfer requests
        for (int i = 0; i <= DEPTH; i++) begin
            chk("R6 tx_req_n", dma_tx_req_n, (i == 0) ? 0 : 1);
            push_tx(8'((i * 7 + 3) & 8'hFF));
            chk("R2 tx level", tx_level, (i + 1 > DEPTH) ? DEPTH : i + 1);
        end
        // R3 order, then pop of empty ignored
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 order", tx_rdata, (i * 7 + 3) & 8'hFF);
            pop_tx();
        end
        pop_tx();
        chk("R3 empty pop", tx_level, 0);

        // R7 burst transmit requests
        wr_cfg(8'h09);
        chk("R11 same enable keeps", busy, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R7 fill low", dma_tx_req_n, 0);
            push_tx(8'(i));
        end
        chk("R7 full high", dma_tx_req_n, 1);
        for (int i = DEPTH; i > 1; i--) begin
            pop_tx();
            chk("R7 drain high", dma_tx_req_n, 1);
        end
        pop_tx();
        chk("R7 empty low", dma_tx_req_n, 0);

        // R4/R5/R8 threshold sweep over every code and level
        afc_en = 1'b1;
        for (int code = 0; code < 4; code++) begin
            wr_cfg(8'((code << 6) | 8'h03));
            for (int lvl = 0; lvl <= DEPTH; lvl++) begin
                chk("R4 rx_avail", rx_avail, (lvl >= thr_of(code)) ? 1 : 0);
                chk("R5 rts_n", rts_n, (lvl >= thr_of(code)) ? 1 : 0);
                chk("R8 rx_req_n", dma_rx_req_n, (lvl == 0) ? 1 : 0);
                if (lvl < DEPTH) push_rx(8'(lvl));
            end
        end
        afc_en = 1'b0; #1;
        chk("R5 afc off", rts_n, 0);

        // R9 burst receive with threshold 4, flush rx first
        wr_cfg(8'h4B);
        push_rx(8'h10);
        chk("R9 below thr", dma_rx_req_n, 1);
        for (int i = 2; i <= 4; i++) push_rx(8'(i));
        chk("R9 at thr", dma_rx_req_n, 0);
        for (int i = 4; i > 1; i--) begin
            pop_rx();
            chk("R9 latched", dma_rx_req_n, 0);
        end
        pop_rx();
        chk("R9 empty", dma_rx_req_n, 1);
        push_rx(8'h20);
        chk("R9 relatch clear", dma_rx_req_n, 1);
        rx_timeout = 1'b1; #1;
        chk("R9 timeout", dma_rx_req_n, 0);
        tick(); rx_timeout = 1'b0; #1;
        chk("R9 timeout held", dma_rx_req_n, 0);
        pop_rx();
        chk("R9 timeout cleared", dma_rx_req_n, 1);

        // R10 separate flushes, not retained
        push_rx(8'h31); push_rx(8'h32);
        push_tx(8'h41); push_tx(8'h42); push_tx(8'h43);
        wr_cfg(8'h0D);
        chk("R10 tx flushed", tx_level, 0);
        chk("R10 rx kept", rx_level, 2);
        repeat (10) tick();
        push_tx(8'h51); push_tx(8'h52);
        wr_cfg(8'h09);
        chk("R10 not retained", tx_level, 2);
        chk("R12 no busy", busy, 0);
        chk("R3 data after flush", tx_rdata, 8'h51);

        // R11 disable flushes both
        wr_cfg(8'h08);
        chk("R11 tx", tx_level, 0);
        chk("R11 rx", rx_level, 0);

        // R4 holding mode threshold is 1; R2 capacity 1
        afc_en = 1'b1;
        wr_cfg(8'hC8);
        push_rx(8'h61);
        chk("R4 hold thr", rx_avail, 1);
        chk("R5 hold rts", rts_n, 1);
        push_rx(8'h62);
        chk("R2 rx hold cap", rx_level, 1);
        afc_en = 1'b0;

        // R13 flush beats simultaneous push
        wr_cfg(8'h09);
        push_tx(8'h71);
        tx_wdata = 8'h72; tx_push = 1'b1; cfg_wdata = 8'h0D; cfg_we = 1'b1;
        tick();
        tx_push = 1'b0; cfg_we = 1'b0; #1;
        chk("R13 flush priority", tx_level, 0);

        finish_run();
    end

endmodule